// File: doc/BRIEF.md
# Banked Thread-Context Register File

This block keeps the architectural state of four resident threads for a processor that changes thread only on long-latency events. Each thread slot (a frame) has its own 32 general registers, its own program-counter pair (current and next fetch address) and its own processor state word. Eight shared registers sit beside the frames and are reached the same way from any thread. A current-frame pointer decides which frame every non-shared access reaches.

The pipeline addresses registers with a 6-bit index: 0 to 7 reach the shared registers, 8 to 39 reach the current frame. The pointer can be stepped up or down with wraparound, copied to or loaded from a register, and the state word can be moved to or from a register. A thread change is requested with a target frame. The block then holds the fetch state frozen until the pipeline reports that it has drained, and then moves the pointer. The outgoing frame's program-counter pair stays where it is, ready for the thread's return.

Top module: `rf_multiframe`

## Requirements
- R1: After reset the frame pointer is 0, sw_busy_o is 0, every register reads 0, every state word is 0, and in every frame the fetch pair is BOOT_ADDR and BOOT_ADDR+4.
- R2: Indices 0 to 7 select shared registers. A value written to one of them is read back unchanged whichever frame is current.
- R3: Indices 8 to 39 select register (index-8) of the current frame. A write to one frame leaves the same index in every other frame unchanged.
- R4: Indices 40 to 63 read as 0 and a write to them changes no register.
- R5: op_i=1 increments the frame pointer and op_i=2 decrements it, both modulo 4 (3 steps up to 0, 0 steps down to 3).
- R6: op_i=3 loads the frame pointer from bits [1:0] of the register selected by rd_a_idx_i. op_i=4 writes the frame pointer, zero-extended, to the register at wr_idx_i. A pointer change is seen by accesses from the next cycle on, and reads in the same cycle use the old pointer.
- R7: Each frame has its own state word. op_i=5 loads the current frame's word from the register at rd_a_idx_i. op_i=6 writes it to the register at wr_idx_i. psr_o shows the current frame's word.
- R8: pc_o and npc_o show the current frame's fetch pair. When pc_adv_i is high and no switch is pending, the next cycle has pc_o equal to the old npc_o and npc_o equal to pc_next_i.
- R9: sw_req_i while idle sets sw_busy_o on the next cycle and latches sw_frame_i. In the cycle after drain_done_i is seen while busy, sw_busy_o is low and the pointer equals the latched target. The old frame's fetch pair is kept.
- R10: While sw_busy_o is high, pc_adv_i, sw_req_i and the pointer operations (op_i 1 to 3) have no effect.
- R11: When op_i is 4 or 6, the register write takes that value and ignores wr_en_i and wr_data_i. op_i 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 6 | Read port A index; also the source of op_i 3 and 5 |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 6 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 6 | Register write index |
| wr_data_i | input | 32 | Register write data |
| op_i | input | 3 | Frame/state operation code |
| pc_adv_i | input | 1 | Advance the current frame's fetch pair |
| pc_next_i | input | 32 | New next-fetch address |
| pc_o | output | 32 | Current frame fetch address |
| npc_o | output | 32 | Current frame next-fetch address |
| psr_o | output | 32 | Current frame state word |
| fp_o | output | 2 | Current frame pointer |
| sw_req_i | input | 1 | Thread change request |
| sw_frame_i | input | 2 | Target frame of the request |
| drain_done_i | input | 1 | Pipeline has drained |
| sw_busy_o | output | 1 | Thread change pending |

## Verification
The assertions check on every cycle that increment and decrement wrap, that the pointer and the fetch pair stay frozen while a switch waits for drain, that a switch enters and leaves the busy state on the right cycles, that an advance moves the fetch pair, and that indices above 39 read zero. Whether each frame's registers and state word stay apart from the others, whether shared registers are seen from every frame, and how register-sourced pointer loads and pointer-to-register copies behave are data-dependent across many cycles. Only the bench shows these, by comparing every read against its own model of all frames under random traffic.

// File: rtl/rf_mf_pkg.sv
package rf_mf_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_FP_INC     = 3'd1,
    OP_FP_DEC     = 3'd2,
    OP_REG_TO_FP  = 3'd3,
    OP_FP_TO_REG  = 3'd4,
    OP_REG_TO_PSR = 3'd5,
    OP_PSR_TO_REG = 3'd6,
    OP_RSVD       = 3'd7
  } rf_op_e;
endpackage

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
  parameter int DATA_W      = 32,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_GLOBALS = 8,
  parameter int FRAME_REGS  = 32,
  parameter int IDX_W       = 6,
  parameter int FP_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FP_W-1:0]   fp_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i [2],
  output logic [DATA_W-1:0] rdata_o [2]
);
  localparam int GW = $clog2(NUM_GLOBALS);
  localparam int RW = $clog2(FRAME_REGS);
  localparam logic [IDX_W-1:0] G_LIM = IDX_W'(NUM_GLOBALS);
  localparam logic [IDX_W-1:0] T_LIM = IDX_W'(NUM_GLOBALS + FRAME_REGS);

  logic [DATA_W-1:0] glb_q [NUM_GLOBALS];
  logic [DATA_W-1:0] frm_q [NUM_FRAMES][FRAME_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GLOBALS; g++) glb_q[g] <= '0;
      for (int f = 0; f < NUM_FRAMES; f++)
        for (int r = 0; r < FRAME_REGS; r++) frm_q[f][r] <= '0;
    end else if (we_i) begin
      if (widx_i < G_LIM) glb_q[GW'(widx_i)] <= wdata_i;
      else if (widx_i < T_LIM) frm_q[fp_i][RW'(widx_i - G_LIM)] <= wdata_i;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (ridx_i[p] < G_LIM) rdata_o[p] = glb_q[GW'(ridx_i[p])];
      else if (ridx_i[p] < T_LIM) rdata_o[p] = frm_q[fp_i][RW'(ridx_i[p] - G_LIM)];
      else rdata_o[p] = '0;
    end
  end
endmodule

// File: rtl/rf_ctx_state.sv
module rf_ctx_state #(
  parameter int          DATA_W     = 32,
  parameter int          NUM_FRAMES = 4,
  parameter int          FP_W       = 2,
  parameter int unsigned BOOT_ADDR  = 32'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FP_W-1:0]   fp_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic              psr_we_i,
  input  logic [DATA_W-1:0] psr_wdata_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] npc_o,
  output logic [DATA_W-1:0] psr_o
);
  localparam logic [DATA_W-1:0] BOOT_PC  = DATA_W'(BOOT_ADDR);
  localparam logic [DATA_W-1:0] BOOT_NPC = DATA_W'(BOOT_ADDR + 4);

  logic [DATA_W-1:0] pc_arr  [NUM_FRAMES];
  logic [DATA_W-1:0] npc_arr [NUM_FRAMES];
  logic [DATA_W-1:0] psr_arr [NUM_FRAMES];

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic [DATA_W-1:0] pc_q, npc_q, psr_q;
    logic sel;
    assign sel = (fp_i == FP_W'(f));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q  <= BOOT_PC;
        npc_q <= BOOT_NPC;
        psr_q <= '0;
      end else begin
        if (adv_i && sel) begin
          pc_q  <= npc_q;
          npc_q <= next_pc_i;
        end
        if (psr_we_i && sel) psr_q <= psr_wdata_i;
      end
    end

    assign pc_arr[f]  = pc_q;
    assign npc_arr[f] = npc_q;
    assign psr_arr[f] = psr_q;
  end

  assign pc_o  = pc_arr[fp_i];
  assign npc_o = npc_arr[fp_i];
  assign psr_o = psr_arr[fp_i];
endmodule

// File: rtl/rf_frame_ctl.sv
module rf_frame_ctl
  import rf_mf_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int FP_W       = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  rf_op_e          op_i,
  input  logic [FP_W-1:0] reg_fp_i,
  input  logic            sw_req_i,
  input  logic [FP_W-1:0] sw_frame_i,
  input  logic            drain_done_i,
  output logic [FP_W-1:0] fp_o,
  output logic            busy_o
);
  localparam logic [FP_W-1:0] LAST = FP_W'(NUM_FRAMES - 1);

  logic [FP_W-1:0] fp_q, tgt_q;
  logic            busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q   <= '0;
      tgt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (sw_req_i) begin
        busy_q <= 1'b1;
        tgt_q  <= sw_frame_i;
      end
      unique case (op_i)
        OP_FP_INC:    fp_q <= (fp_q == LAST) ? '0 : fp_q + 1'b1;
        OP_FP_DEC:    fp_q <= (fp_q == '0) ? LAST : fp_q - 1'b1;
        OP_REG_TO_FP: fp_q <= reg_fp_i;
        default:      ;
      endcase
    end else if (drain_done_i) begin
      // pipeline empty: old frame's PC chain stays in place
      busy_q <= 1'b0;
      fp_q   <= tgt_q;
    end
  end

  assign fp_o   = fp_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/rf_multiframe.sv
module rf_multiframe
  import rf_mf_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          NUM_FRAMES  = 4,
  parameter int          NUM_GLOBALS = 8,
  parameter int          FRAME_REGS  = 32,
  parameter int unsigned BOOT_ADDR   = 32'h100,
  localparam int         FP_W        = $clog2(NUM_FRAMES),
  localparam int         IDX_W       = $clog2(NUM_GLOBALS + FRAME_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        op_i,
  input  logic              pc_adv_i,
  input  logic [DATA_W-1:0] pc_next_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] npc_o,
  output logic [DATA_W-1:0] psr_o,
  output logic [FP_W-1:0]   fp_o,
  input  logic              sw_req_i,
  input  logic [FP_W-1:0]   sw_frame_i,
  input  logic              drain_done_i,
  output logic              sw_busy_o
);
  rf_op_e            op;
  logic [FP_W-1:0]   fp;
  logic              busy;
  logic              we;
  logic [DATA_W-1:0] wdata;
  logic [IDX_W-1:0]  ridx [2];
  logic [DATA_W-1:0] rdata [2];

  assign op      = rf_op_e'(op_i);
  assign ridx[0] = rd_a_idx_i;
  assign ridx[1] = rd_b_idx_i;

  // special-op writes override the plain write port
  always_comb begin
    we    = wr_en_i;
    wdata = wr_data_i;
    if (op == OP_FP_TO_REG) begin
      we    = 1'b1;
      wdata = {{(DATA_W-FP_W){1'b0}}, fp};
    end else if (op == OP_PSR_TO_REG) begin
      we    = 1'b1;
      wdata = psr_o;
    end
  end

  rf_gpr_bank #(
    .DATA_W(DATA_W), .NUM_FRAMES(NUM_FRAMES), .NUM_GLOBALS(NUM_GLOBALS),
    .FRAME_REGS(FRAME_REGS), .IDX_W(IDX_W), .FP_W(FP_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp),
    .we_i(we), .widx_i(wr_idx_i), .wdata_i(wdata),
    .ridx_i(ridx), .rdata_o(rdata)
  );

  rf_ctx_state #(
    .DATA_W(DATA_W), .NUM_FRAMES(NUM_FRAMES), .FP_W(FP_W), .BOOT_ADDR(BOOT_ADDR)
  ) u_ctx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp),
    .adv_i(pc_adv_i && !busy), .next_pc_i(pc_next_i),
    .psr_we_i(op == OP_REG_TO_PSR), .psr_wdata_i(rdata[0]),
    .pc_o(pc_o), .npc_o(npc_o), .psr_o(psr_o)
  );

  rf_frame_ctl #(.NUM_FRAMES(NUM_FRAMES), .FP_W(FP_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .reg_fp_i(rdata[0][FP_W-1:0]),
    .sw_req_i(sw_req_i), .sw_frame_i(sw_frame_i), .drain_done_i(drain_done_i),
    .fp_o(fp), .busy_o(busy)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];
  assign fp_o        = fp;
  assign sw_busy_o   = busy;
endmodule

// File: rtl/rf_multiframe_chk.sv
module rf_multiframe_chk #(
  parameter int DATA_W      = 32,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_GLOBALS = 8,
  parameter int FRAME_REGS  = 32,
  parameter int FP_W        = 2,
  parameter int IDX_W       = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [2:0]        op_i,
  input logic              pc_adv_i,
  input logic [DATA_W-1:0] pc_next_i,
  input logic [DATA_W-1:0] pc_o,
  input logic [DATA_W-1:0] npc_o,
  input logic [FP_W-1:0]   fp_o,
  input logic              sw_req_i,
  input logic              drain_done_i,
  input logic              sw_busy_o
);
  localparam logic [FP_W-1:0]  LAST  = FP_W'(NUM_FRAMES - 1);
  localparam logic [IDX_W-1:0] T_LIM = IDX_W'(NUM_GLOBALS + FRAME_REGS);

  logic fp_op;
  assign fp_op = (op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd3);

  a_r1_reset_fp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (fp_o == '0) && !sw_busy_o);

  a_r5_inc_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_busy_o && op_i == 3'd1) |=>
      fp_o == (($past(fp_o) == LAST) ? '0 : $past(fp_o) + 1'b1));

  a_r5_dec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_busy_o && op_i == 3'd2) |=>
      fp_o == (($past(fp_o) == '0) ? LAST : $past(fp_o) - 1'b1));

  a_r9_enter_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_busy_o && sw_req_i) |=> sw_busy_o);

  a_r9_leave_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_busy_o && drain_done_i) |=> !sw_busy_o);

  a_r10_fp_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_busy_o && !drain_done_i) |=> $stable(fp_o) && sw_busy_o);

  a_r10_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_busy_o && !drain_done_i) |=> $stable(pc_o) && $stable(npc_o));

  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_busy_o && pc_adv_i && !fp_op) |=>
      (pc_o == $past(npc_o)) && (npc_o == $past(pc_next_i)));

  a_r4_high_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i >= T_LIM) |-> (rd_a_data_o == '0));
endmodule

bind rf_multiframe rf_multiframe_chk #(
  .DATA_W(DATA_W), .NUM_FRAMES(NUM_FRAMES), .NUM_GLOBALS(NUM_GLOBALS),
  .FRAME_REGS(FRAME_REGS), .FP_W(FP_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
  .op_i(op_i), .pc_adv_i(pc_adv_i), .pc_next_i(pc_next_i), .pc_o(pc_o), .npc_o(npc_o),
  .fp_o(fp_o), .sw_req_i(sw_req_i), .drain_done_i(drain_done_i), .sw_busy_o(sw_busy_o)
);

// File: tb/tb_rf_multiframe.sv
`timescale 1ns/1ps
module tb_rf_multiframe;
  localparam int unsigned BOOT = 32'h100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0, pc_next_i = '0;
  logic        wr_en_i = 1'b0, pc_adv_i = 1'b0, sw_req_i = 1'b0, drain_done_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  sw_frame_i = '0, fp_o;
  logic [31:0] pc_o, npc_o, psr_o;
  logic        sw_busy_o;

  always #2.5 clk = ~clk;

  rf_multiframe #(.BOOT_ADDR(BOOT)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .op_i(op_i), .pc_adv_i(pc_adv_i), .pc_next_i(pc_next_i),
    .pc_o(pc_o), .npc_o(npc_o), .psr_o(psr_o), .fp_o(fp_o),
    .sw_req_i(sw_req_i), .sw_frame_i(sw_frame_i), .drain_done_i(drain_done_i),
    .sw_busy_o(sw_busy_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_glb [8];
  logic [31:0] m_frm [4][32];
  logic [31:0] m_pc [4], m_npc [4], m_psr [4];
  logic [1:0]  m_fp, m_tgt;
  logic        m_busy;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int idx);
    if (idx < 8) return m_glb[idx];
    if (idx < 40) return m_frm[m_fp][idx-8];
    return 32'h0;
  endfunction

  function automatic string rtag(int idx);
    if (idx < 8) return "R2";
    if (idx < 40) return "R3";
    return "R4";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_glb[i] = '0;
    for (int f = 0; f < 4; f++) begin
      for (int r = 0; r < 32; r++) m_frm[f][r] = '0;
      m_pc[f] = BOOT; m_npc[f] = BOOT + 4; m_psr[f] = '0;
    end
    m_fp = '0; m_tgt = '0; m_busy = 1'b0;
  endtask

  task automatic check_outputs();
    chk(rtag(int'(rd_a_idx_i)), "read A", rd_a_data_o, m_read(int'(rd_a_idx_i)));
    chk(rtag(int'(rd_b_idx_i)), "read B", rd_b_data_o, m_read(int'(rd_b_idx_i)));
    chk("R8", "pc", pc_o, m_pc[m_fp]);
    chk("R8", "npc", npc_o, m_npc[m_fp]);
    chk("R7", "psr", psr_o, m_psr[m_fp]);
    chk("R5", "fp", {30'b0, fp_o}, {30'b0, m_fp});
    chk("R9", "busy", {31'b0, sw_busy_o}, {31'b0, m_busy});
  endtask

  task automatic model_update();
    logic [31:0] ra, wd;
    logic        we;
    int          wi;
    ra = m_read(int'(rd_a_idx_i));
    wi = int'(wr_idx_i);
    we = wr_en_i; wd = wr_data_i;
    if (op_i == 3'd4) begin we = 1'b1; wd = {30'b0, m_fp}; end
    else if (op_i == 3'd6) begin we = 1'b1; wd = m_psr[m_fp]; end
    if (we) begin
      if (wi < 8) m_glb[wi] = wd;
      else if (wi < 40) m_frm[m_fp][wi-8] = wd;
    end
    if (op_i == 3'd5) m_psr[m_fp] = ra;
    if (pc_adv_i && !m_busy) begin
      m_pc[m_fp] = m_npc[m_fp];
      m_npc[m_fp] = pc_next_i;
    end
    if (!m_busy) begin
      if (sw_req_i) begin m_busy = 1'b1; m_tgt = sw_frame_i; end
      case (op_i)
        3'd1: m_fp = m_fp + 2'd1;
        3'd2: m_fp = m_fp - 2'd1;
        3'd3: m_fp = ra[1:0];
        default: ;
      endcase
    end else if (drain_done_i) begin
      m_busy = 1'b0; m_fp = m_tgt;
    end
  endtask

  // inputs are set at the falling edge before this call
  task automatic run_cycle();
    #1;
    check_outputs();
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en_i = 0; op_i = 0; pc_adv_i = 0; sw_req_i = 0; drain_done_i = 0;
  endtask

  task automatic do_write(int idx, logic [31:0] d);
    idle_inputs(); wr_en_i = 1; wr_idx_i = 6'(idx); wr_data_i = d; run_cycle();
  endtask

  task automatic do_op(logic [2:0] op, int ra, int wi);
    idle_inputs(); op_i = op; rd_a_idx_i = 6'(ra); wr_idx_i = 6'(wi); run_cycle();
  endtask

  task automatic read_chk(string tag, int idx, logic [31:0] exp);
    idle_inputs(); rd_a_idx_i = 6'(idx); #1;
    chk(tag, "directed read", rd_a_data_o, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1 reset state, every index at frame 0 and fetch pair of every frame
    chk("R1", "fp", {30'b0, fp_o}, 32'h0);
    chk("R1", "busy", {31'b0, sw_busy_o}, 32'h0);
    chk("R1", "pc", pc_o, BOOT);
    chk("R1", "npc", npc_o, BOOT + 4);
    chk("R1", "psr", psr_o, 32'h0);
    for (int i = 0; i < 40; i++) read_chk("R1", i, 32'h0);
    for (int f = 1; f < 4; f++) begin
      do_op(3'd1, 0, 0);
      chk("R1", "pc other frame", pc_o, BOOT);
      chk("R1", "npc other frame", npc_o, BOOT + 4);
    end
    // R5 wrap: fp is 3 here
    do_op(3'd1, 0, 0);
    chk("R5", "inc wraps to 0", {30'b0, fp_o}, 32'h0);
    do_op(3'd2, 0, 0);
    chk("R5", "dec wraps to 3", {30'b0, fp_o}, 32'h3);

    // R3 frame isolation, R2 global sharing
    do_write(9, 32'hAAAA_0003);
    do_write(5, 32'h6106_0005);
    do_op(3'd1, 0, 0);
    read_chk("R3", 9, 32'h0);
    read_chk("R2", 5, 32'h6106_0005);

    // R4 out-of-range write discarded
    do_write(45, 32'hDEAD_BEEF);
    read_chk("R4", 45, 32'h0);
    for (int i = 0; i < 40; i++) begin
      rd_a_idx_i = 6'(i); #1;
      chk("R4", "no alias", rd_a_data_o, m_read(i));
    end

    // R6 load pointer from register, old value seen same cycle
    do_write(1, 32'hFFFF_FFF2);
    idle_inputs(); op_i = 3'd3; rd_a_idx_i = 6'd1; #1;
    chk("R6", "same-cycle fp old", {30'b0, fp_o}, 32'h0);
    run_cycle();
    chk("R6", "fp loaded", {30'b0, fp_o}, 32'h2);
    // R11 pointer copy overrides plain write data
    idle_inputs(); op_i = 3'd4; wr_en_i = 1; wr_idx_i = 6'd3; wr_data_i = 32'h1234_5678;
    run_cycle();
    read_chk("R11", 3, 32'h2);

    // R7 state word per frame
    do_write(12, 32'h0000_00C7);
    do_op(3'd5, 12, 0);
    chk("R7", "psr loaded", psr_o, 32'h0000_00C7);
    do_op(3'd6, 0, 20);
    read_chk("R7", 20, 32'h0000_00C7);
    do_op(3'd1, 0, 0);
    chk("R7", "psr other frame", psr_o, 32'h0);

    // R9/R10 switch with blocked ops during drain
    idle_inputs(); pc_adv_i = 1; pc_next_i = 32'h0000_0400; run_cycle();
    chk("R8", "advance", pc_o, BOOT + 4);
    idle_inputs(); sw_req_i = 1; sw_frame_i = 2'd1; run_cycle();
    chk("R9", "busy set", {31'b0, sw_busy_o}, 32'h1);
    for (int k = 0; k < 3; k++) begin
      idle_inputs(); op_i = 3'd1; pc_adv_i = 1; sw_req_i = 1; sw_frame_i = 2'd0; run_cycle();
      chk("R10", "fp held", {30'b0, fp_o}, 32'h3);
      chk("R10", "pc held", pc_o, BOOT + 4);
    end
    idle_inputs(); drain_done_i = 1; run_cycle();
    chk("R9", "switched fp", {30'b0, fp_o}, 32'h1);
    chk("R9", "busy cleared", {31'b0, sw_busy_o}, 32'h0);
    do_op(3'd3, 1, 0); // back to frame 2
    do_op(3'd1, 0, 0);
    chk("R9", "old frame pc kept", pc_o, BOOT + 4);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      rd_a_idx_i = 6'($urandom_range(0, 47));
      rd_b_idx_i = 6'($urandom_range(0, 47));
      wr_en_i    = 1'($urandom_range(0, 1));
      wr_idx_i   = 6'($urandom_range(0, 47));
      wr_data_i  = $urandom();
      op_i       = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      pc_adv_i   = 1'($urandom_range(0, 1));
      pc_next_i  = $urandom();
      sw_req_i   = ($urandom_range(0, 15) == 0);
      sw_frame_i = 2'($urandom_range(0, 3));
      drain_done_i = ($urandom_range(0, 3) == 0);
      run_cycle();
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule